// File: doc/BRIEF.md
# Banked Mode and Exception-Entry Status Unit

This block keeps the live status word of a 32-bit RISC core: the four condition flags, two interrupt-disable bits and a 5-bit processor-mode field. For every privileged mode it also keeps a saved copy of the status word, plus its own stack-pointer and link-register slot. User and system mode share one slot. The other parts of the core use its outputs to find the active mode, the flags, the interrupt masks and the banked stack and link values. They also use the vector code, which tells the fetch logic where to go after an exception has been taken.

Four sources can start an exception. These are a fast interrupt request, a normal interrupt request, an undefined-instruction strobe and a software-interrupt strobe. When one is taken, the unit does all of the following in a single clock edge: it saves the old status word into the target mode's saved-status slot, writes PC+4 into that mode's link slot, switches the mode and sets the disable bits. An exception-return strobe copies the saved word back. Status writes are filtered. They can be limited to the flags, a full write from user mode is dropped, and a full write that carries an unknown mode code is dropped.

Top module: `mode_bank_ctrl`

## Requirements
- R1: While `rst` is high, and after the first rising edge with `rst` high, the unit reports supervisor mode (5'b10011), both disable bits set, flags 4'b0000 and `vec_vld` low.
- R2: When `fiq_req` is high and the fast-disable bit is clear, the next edge enters fast mode (5'b10001), sets both disable bits and raises `vec_vld` with `vec_code` 3'd7. This happens even when `irq_req` is high in the same cycle.
- R3: When `irq_req` is high, the normal-disable bit is clear and no fast interrupt is taken, the next edge enters normal-interrupt mode (5'b10010) with `vec_code` 3'd6. It sets the normal-disable bit and leaves the fast-disable bit unchanged. While the normal-disable bit is set, `irq_req` has no effect.
- R4: When no interrupt is taken, `und_stb` enters undefined mode (5'b11011) with `vec_code` 3'd1. Otherwise `swi_stb` enters supervisor mode with `vec_code` 3'd2. `und_stb` has precedence over `swi_stb`. Both set the normal-disable bit.
- R5: On every exception entry, the status word from before the edge is written to the saved-status slot of the entered mode. `out_spsr` shows the saved word of the current mode, and reads 0 in user or system mode. Word layout: bits 31:28 hold NZCV, bit 7 the normal-disable bit, bit 6 the fast-disable bit, bits 4:0 the mode, and all other bits 0.
- R6: On entry, the link slot of the entered mode receives `pc_in`+4. `bk_we` writes `bk_wdata` into the current mode's stack slot (`bk_sel`=0) or link slot (`bk_sel`=1). `out_sp` and `out_lr` show the current mode's slots. User and system mode share one pair of slots, and every other mode has a pair of its own.
- R7: A status write with `st_flags_only` high changes only the flags, taken from `st_wr_data[31:28]`, in any mode.
- R8: A full status write (`st_flags_only` low) loads the flags, both disable bits and the mode from `st_wr_data` when the current mode is not user. In user mode a full write is ignored.
- R9: A full write whose mode field is not one of the seven legal codes (10000, 10001, 10010, 10011, 10111, 11011, 11111) is ignored completely.
- R10: `ret_stb` restores the live status word from the current mode's saved slot at the next edge. In user or system mode it has no effect.
- R11: When several actions fall in one cycle, exception entry comes first, then return, then status write. The actions that lose are dropped.
- R12: Every result is visible after the next rising edge. `vec_vld` is high only in the cycle after an exception was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fiq_req | input | 1 | Fast interrupt request (level) |
| irq_req | input | 1 | Normal interrupt request (level) |
| swi_stb | input | 1 | Software-interrupt strobe |
| und_stb | input | 1 | Undefined-instruction strobe |
| pc_in | input | DW | PC of the current instruction |
| ret_stb | input | 1 | Exception-return strobe |
| st_wr_en | input | 1 | Status write request |
| st_flags_only | input | 1 | Limit the write to the NZCV flags |
| st_wr_data | input | 32 | Status word to write |
| bk_we | input | 1 | Banked slot write enable |
| bk_sel | input | 1 | 0 = stack slot, 1 = link slot |
| bk_wdata | input | DW | Banked slot write data |
| out_mode | output | 5 | Current mode code |
| out_flags | output | 4 | NZCV flags |
| out_irq_dis | output | 1 | Normal interrupt disabled |
| out_fiq_dis | output | 1 | Fast interrupt disabled |
| out_spsr | output | 32 | Saved status word of the current mode |
| out_sp | output | DW | Banked stack pointer of the current mode |
| out_lr | output | DW | Banked link value of the current mode |
| vec_vld | output | 1 | Exception taken on the previous edge |
| vec_code | output | 3 | Vector index of the taken exception |

## Verification
Every result of this unit falls due exactly one rising edge after the stimulus that causes it. This covers mode and mask changes, the saved-status copy, the link write, banked-slot writes, status writes and returns. The bench applies each stimulus at a falling edge and pushes the expected outputs into a queue. The monitor pops that entry 1 ns after the next rising edge, so each comparison falls in the first cycle in which the new value is valid. The bench does not compare banked slots that have never been written.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int NBANK = 6;
  localparam int BANKW = $clog2(NBANK);

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [2:0] V_UND = 3'd1;
  localparam logic [2:0] V_SWI = 3'd2;
  localparam logic [2:0] V_IRQ = 3'd6;
  localparam logic [2:0] V_FIQ = 3'd7;

  typedef struct packed {
    logic [3:0] nzcv;
    logic       i_dis;
    logic       f_dis;
    logic [4:0] mode;
  } stat_t;

  function automatic logic mode_ok(input logic [4:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // slot 0 is shared by user and system mode
  function automatic logic [BANKW-1:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return BANKW'(1);
      M_IRQ:   return BANKW'(2);
      M_SVC:   return BANKW'(3);
      M_ABT:   return BANKW'(4);
      M_UND:   return BANKW'(5);
      default: return BANKW'(0);
    endcase
  endfunction

  function automatic logic [31:0] pack_word(input stat_t s);
    return {s.nzcv, 20'b0, s.i_dis, s.f_dis, 1'b0, s.mode};
  endfunction
endpackage

// File: rtl/mbc_bank_mem.sv
module mbc_bank_mem #(
  parameter int W  = 32,
  parameter int D  = 6,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  // one write port, asynchronous read: maps to distributed RAM
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mbc_exc_arb.sv
module mbc_exc_arb
  import mbc_pkg::*;
(
  input  logic       fiq_req,
  input  logic       irq_req,
  input  logic       und_stb,
  input  logic       swi_stb,
  input  logic       i_dis,
  input  logic       f_dis,
  output logic       take,
  output logic [4:0] tgt_mode,
  output logic       set_f,
  output logic [2:0] vec
);
  always_comb begin
    take     = 1'b1;
    set_f    = 1'b0;
    tgt_mode = M_SVC;
    vec      = V_SWI;
    if (fiq_req && !f_dis) begin
      tgt_mode = M_FIQ;
      vec      = V_FIQ;
      set_f    = 1'b1;
    end else if (irq_req && !i_dis) begin
      tgt_mode = M_IRQ;
      vec      = V_IRQ;
    end else if (und_stb) begin
      tgt_mode = M_UND;
      vec      = V_UND;
    end else if (!swi_stb) begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/mode_bank_ctrl.sv
module mode_bank_ctrl
  import mbc_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LINK_OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fiq_req,
  input  logic          irq_req,
  input  logic          swi_stb,
  input  logic          und_stb,
  input  logic [DW-1:0] pc_in,
  input  logic          ret_stb,
  input  logic          st_wr_en,
  input  logic          st_flags_only,
  input  logic [31:0]   st_wr_data,
  input  logic          bk_we,
  input  logic          bk_sel,
  input  logic [DW-1:0] bk_wdata,
  output logic [4:0]    out_mode,
  output logic [3:0]    out_flags,
  output logic          out_irq_dis,
  output logic          out_fiq_dis,
  output logic [31:0]   out_spsr,
  output logic [DW-1:0] out_sp,
  output logic [DW-1:0] out_lr,
  output logic          vec_vld,
  output logic [2:0]    vec_code
);
  stat_t            st;
  logic             take, set_f;
  logic [4:0]       tgt_mode;
  logic [2:0]       vec;
  logic [BANKW-1:0] cur_bank, tgt_bank;
  logic             has_saved;
  logic [31:0]      saved_rd;
  logic             lr_we;
  logic [BANKW-1:0] lr_addr;
  logic [DW-1:0]    lr_wdata;
  logic             unused_bits;

  assign cur_bank  = bank_of(st.mode);
  assign tgt_bank  = bank_of(tgt_mode);
  assign has_saved = (cur_bank != '0);
  assign unused_bits = ^{st_wr_data[27:8], st_wr_data[5], saved_rd[27:8], saved_rd[5]};

  mbc_exc_arb u_arb (
    .fiq_req (fiq_req), .irq_req (irq_req), .und_stb (und_stb), .swi_stb (swi_stb),
    .i_dis (st.i_dis), .f_dis (st.f_dis),
    .take (take), .tgt_mode (tgt_mode), .set_f (set_f), .vec (vec)
  );

  // saved status, one slot per privileged mode (slot 0 unused)
  mbc_bank_mem #(.W(32), .D(NBANK)) u_saved (
    .clk (clk), .we (take), .waddr (tgt_bank), .wdata (pack_word(st)),
    .raddr (cur_bank), .rdata (saved_rd)
  );

  // link slots: exception entry owns the single write port
  assign lr_we    = take || (bk_we && bk_sel);
  assign lr_addr  = take ? tgt_bank : cur_bank;
  assign lr_wdata = take ? (pc_in + DW'(LINK_OFS)) : bk_wdata;

  mbc_bank_mem #(.W(DW), .D(NBANK)) u_lr (
    .clk (clk), .we (lr_we), .waddr (lr_addr), .wdata (lr_wdata),
    .raddr (cur_bank), .rdata (out_lr)
  );

  mbc_bank_mem #(.W(DW), .D(NBANK)) u_sp (
    .clk (clk), .we (bk_we && !bk_sel), .waddr (cur_bank), .wdata (bk_wdata),
    .raddr (cur_bank), .rdata (out_sp)
  );

  // live status word: entry > return > write
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '{nzcv: 4'b0, i_dis: 1'b1, f_dis: 1'b1, mode: M_SVC};
      vec_vld <= 1'b0;
      vec_code <= '0;
    end else begin
      vec_vld  <= take;
      vec_code <= take ? vec : '0;
      if (take) begin
        st.mode  <= tgt_mode;
        st.i_dis <= 1'b1;
        if (set_f) st.f_dis <= 1'b1;
      end else if (ret_stb && has_saved) begin
        st.nzcv  <= saved_rd[31:28];
        st.i_dis <= saved_rd[7];
        st.f_dis <= saved_rd[6];
        st.mode  <= saved_rd[4:0];
      end else if (st_wr_en) begin
        if (st_flags_only) begin
          st.nzcv <= st_wr_data[31:28];
        end else if (st.mode != M_USR && mode_ok(st_wr_data[4:0])) begin
          st.nzcv  <= st_wr_data[31:28];
          st.i_dis <= st_wr_data[7];
          st.f_dis <= st_wr_data[6];
          st.mode  <= st_wr_data[4:0];
        end
      end
    end
  end

  assign out_mode    = st.mode;
  assign out_flags   = st.nzcv;
  assign out_irq_dis = st.i_dis;
  assign out_fiq_dis = st.f_dis;
  assign out_spsr    = has_saved ? saved_rd : 32'b0;

  // ---------------- assertions ----------------
  a_r2_fiq_first: assert property (@(posedge clk) disable iff (rst)
    (fiq_req && !out_fiq_dis) |=> (out_mode == M_FIQ && out_fiq_dis && out_irq_dis
                                   && vec_vld && vec_code == V_FIQ));

  a_r3_irq_entry: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !out_irq_dis && !(fiq_req && !out_fiq_dis))
      |=> (out_mode == M_IRQ && out_irq_dis && $stable(out_fiq_dis)));

  a_r5_save_old: assert property (@(posedge clk) disable iff (rst)
    take |=> out_spsr == $past({out_flags, 20'b0, out_irq_dis, out_fiq_dis, 1'b0, out_mode}));

  a_r6_link_pc4: assert property (@(posedge clk) disable iff (rst)
    take |=> out_lr == $past(pc_in) + DW'(LINK_OFS));

  a_r7_flags_only: assert property (@(posedge clk) disable iff (rst)
    (st_wr_en && st_flags_only && !take && !ret_stb)
      |=> (out_flags == $past(st_wr_data[31:28]) && $stable(out_mode)
           && $stable(out_irq_dis) && $stable(out_fiq_dis)));

  a_r8_user_lock: assert property (@(posedge clk) disable iff (rst)
    (st_wr_en && !st_flags_only && out_mode == M_USR && !take)
      |=> (out_mode == M_USR && $stable(out_irq_dis) && $stable(out_fiq_dis)));

  a_r9_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_ok(out_mode));

  a_r10_return: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && !take && out_mode != M_USR && out_mode != M_SYS)
      |=> {out_flags, 20'b0, out_irq_dis, out_fiq_dis, 1'b0, out_mode} == $past(out_spsr));

  a_r12_vec_pulse: assert property (@(posedge clk) disable iff (rst)
    !take |=> !vec_vld);
endmodule

// File: tb/mode_bank_ctrl_tb_top.sv
module mode_bank_ctrl_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic fiq_req, irq_req, swi_stb, und_stb, ret_stb, st_wr_en, st_flags_only, bk_we, bk_sel;
  logic [31:0] pc_in, st_wr_data, bk_wdata;
  logic [4:0]  out_mode;
  logic [3:0]  out_flags;
  logic        out_irq_dis, out_fiq_dis, vec_vld;
  logic [31:0] out_spsr, out_sp, out_lr;
  logic [2:0]  vec_code;

  always #(PERIOD/2) clk = ~clk;

  mode_bank_ctrl dut_i (
    .clk, .rst, .fiq_req, .irq_req, .swi_stb, .und_stb, .pc_in, .ret_stb,
    .st_wr_en, .st_flags_only, .st_wr_data, .bk_we, .bk_sel, .bk_wdata,
    .out_mode, .out_flags, .out_irq_dis, .out_fiq_dis, .out_spsr, .out_sp,
    .out_lr, .vec_vld, .vec_code
  );

  typedef struct {
    logic [4:0] mode; logic [3:0] flags; logic i; logic f;
    logic vv; logic [2:0] vec;
    logic c_spsr; logic [31:0] spsr;
    logic c_sp;   logic [31:0] sp;
    logic c_lr;   logic [31:0] lr;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, bad = 0;
  bit done = 0;

  function automatic exp_t mk(logic [4:0] m, logic [3:0] fl, logic i, logic f,
                              logic vv, logic [2:0] vec, string tag);
    exp_t e;
    e.mode = m; e.flags = fl; e.i = i; e.f = f; e.vv = vv; e.vec = vec;
    e.c_spsr = 0; e.spsr = 0; e.c_sp = 0; e.sp = 0; e.c_lr = 0; e.lr = 0; e.tag = tag;
    return e;
  endfunction

  task automatic idle();
    fiq_req = 0; irq_req = 0; swi_stb = 0; und_stb = 0; ret_stb = 0;
    st_wr_en = 0; st_flags_only = 0; st_wr_data = 0; bk_we = 0; bk_sel = 0;
    bk_wdata = 0; pc_in = 0;
  endtask

  // driver: inputs are set by the caller after a falling edge
  task automatic cyc(exp_t e);
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "mode", 32'(out_mode), 32'(e.mode));
        cmp(e.tag, "flags", 32'(out_flags), 32'(e.flags));
        cmp(e.tag, "irq_dis", 32'(out_irq_dis), 32'(e.i));
        cmp(e.tag, "fiq_dis", 32'(out_fiq_dis), 32'(e.f));
        cmp(e.tag, "vec_vld", 32'(vec_vld), 32'(e.vv));
        if (e.vv) cmp(e.tag, "vec_code", 32'(vec_code), 32'(e.vec));
        if (e.c_spsr) cmp(e.tag, "spsr", out_spsr, e.spsr);
        if (e.c_sp) cmp(e.tag, "sp", out_sp, e.sp);
        if (e.c_lr) cmp(e.tag, "lr", out_lr, e.lr);
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, UND = 5'b11011, SYS = 5'b11111;

  initial begin
    exp_t e;
    idle();
    rst = 1;
    @(negedge clk);
    // R1 reset state
    cyc(mk(SVC, 4'h0, 1, 1, 0, 0, "R1"));
    rst = 0;

    // R8 full write from supervisor to system, flags A, masks clear
    st_wr_en = 1; st_wr_data = 32'hA000_001F;
    cyc(mk(SYS, 4'hA, 0, 0, 0, 0, "R8"));

    // R6 banked writes in system mode
    bk_we = 1; bk_sel = 0; bk_wdata = 32'h1111;
    e = mk(SYS, 4'hA, 0, 0, 0, 0, "R6"); e.c_sp = 1; e.sp = 32'h1111; cyc(e);
    bk_we = 1; bk_sel = 1; bk_wdata = 32'h2222;
    e = mk(SYS, 4'hA, 0, 0, 0, 0, "R6"); e.c_lr = 1; e.lr = 32'h2222; cyc(e);

    // R2 fast and normal together: fast wins; R5 saved copy; R6 link
    fiq_req = 1; irq_req = 1; pc_in = 32'h100;
    e = mk(FIQ, 4'hA, 1, 1, 1, 3'd7, "R2");
    e.c_spsr = 1; e.spsr = 32'hA000_001F; e.c_lr = 1; e.lr = 32'h104; cyc(e);

    // R6 fast bank has its own stack slot; R12 vec pulse drops
    bk_we = 1; bk_sel = 0; bk_wdata = 32'h3333;
    e = mk(FIQ, 4'hA, 1, 1, 0, 0, "R12"); e.c_sp = 1; e.sp = 32'h3333; cyc(e);

    // R3 normal request masked while disabled
    irq_req = 1;
    cyc(mk(FIQ, 4'hA, 1, 1, 0, 0, "R3"));

    // R10 return to system; R6 shared user/system slots intact
    ret_stb = 1;
    e = mk(SYS, 4'hA, 0, 0, 0, 0, "R10");
    e.c_sp = 1; e.sp = 32'h1111; e.c_lr = 1; e.lr = 32'h2222; e.c_spsr = 1; e.spsr = 0; cyc(e);

    // R3 normal interrupt entry
    irq_req = 1; pc_in = 32'h200;
    e = mk(IRQ, 4'hA, 1, 0, 1, 3'd6, "R3");
    e.c_spsr = 1; e.spsr = 32'hA000_001F; e.c_lr = 1; e.lr = 32'h204; cyc(e);

    // R7 flags-only write touches only the flags
    st_wr_en = 1; st_flags_only = 1; st_wr_data = 32'h5000_00D0;
    cyc(mk(IRQ, 4'h5, 1, 0, 0, 0, "R7"));

    // R9 illegal mode code ignored
    st_wr_en = 1; st_wr_data = 32'h3000_0015;
    cyc(mk(IRQ, 4'h5, 1, 0, 0, 0, "R9"));

    // R4 undefined beats software interrupt
    und_stb = 1; swi_stb = 1; pc_in = 32'h300;
    e = mk(UND, 4'h5, 1, 0, 1, 3'd1, "R4");
    e.c_spsr = 1; e.spsr = 32'h5000_0092; e.c_lr = 1; e.lr = 32'h304; cyc(e);

    // R8 drop to user; R5 saved read is 0 in user
    st_wr_en = 1; st_wr_data = 32'h0000_0010;
    e = mk(USR, 4'h0, 0, 0, 0, 0, "R8"); e.c_spsr = 1; e.spsr = 0; cyc(e);

    // R8 full write in user ignored
    st_wr_en = 1; st_wr_data = 32'h0000_00D3;
    cyc(mk(USR, 4'h0, 0, 0, 0, 0, "R8"));

    // R7 flags-only write allowed in user
    st_wr_en = 1; st_flags_only = 1; st_wr_data = 32'hF000_0000;
    cyc(mk(USR, 4'hF, 0, 0, 0, 0, "R7"));

    // R10 return ignored in user
    ret_stb = 1;
    cyc(mk(USR, 4'hF, 0, 0, 0, 0, "R10"));

    // R11 entry beats return and write; R4 software interrupt
    swi_stb = 1; ret_stb = 1; st_wr_en = 1; st_wr_data = 32'h0000_001F; pc_in = 32'h400;
    e = mk(SVC, 4'hF, 1, 0, 1, 3'd2, "R11");
    e.c_spsr = 1; e.spsr = 32'hF000_0010; e.c_lr = 1; e.lr = 32'h404; cyc(e);

    // R11 return beats write
    ret_stb = 1; st_wr_en = 1; st_wr_data = 32'h0000_001F;
    e = mk(USR, 4'hF, 0, 0, 0, 0, "R11");
    e.c_sp = 1; e.sp = 32'h1111; e.c_lr = 1; e.lr = 32'h2222; cyc(e);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule